// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a Clause 22 MDIO master sitting behind a small 32-bit register port. A host packs a whole management transaction into one command word: a valid flag, the PHY address, the register address, the write data and a read or write opcode. The controller then serializes the frame on MDC/MDIO. While the frame is in progress it shows a busy flag. On a read it captures the 16-bit PHY value and an error flag.

MDC is generated from the system clock by a parameterizable divider and runs freely. The line is driven on falling MDC edges and sampled on rising MDC edges. During a read the master releases the line from the turnaround onwards. A PHY that does not pull the second turnaround bit low marks the result as failed.

Software polls busy until it is clear, writes a command, then polls busy again before it fetches a read result.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, every register reads zero and `mdio_oe_o` is low. Offsets other than 0x0, 0x8 and 0xC also read zero.
- R2: A command is accepted when all of the following hold on a write to offset 0x8: the controller is not busy, bit 31 is 1, and exactly one of bit 1 (write) and bit 2 (read) is 1. Status bit 3 (busy) reads 1 from the next clock until the frame has completed.
- R3: A write to offset 0x8 while busy is ignored. The command readback does not change and no second frame is sent.
- R4: A write to offset 0x8 is ignored in either of these cases: bit 31 is 0, or bits 2:1 are 00 or 11. Busy stays 0 and the command readback does not change.
- R5: Offset 0x8 reads back the last accepted command with bit 31 cleared. In that word, bits 29:25 are the PHY address, bits 24:20 the register address and bits 19:4 the write data.
- R6: MDC has a period of 2*DIV_HALF clocks. `mdio_o` and `mdio_oe_o` change only on clock edges where MDC falls.
- R7: A frame is 64 MDC cycles, sent MSB first. It consists of 32 ones, then start 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address, the 5-bit register address, the turnaround (10 on a write), and finally 16 data bits.
- R8: On a read, `mdio_oe_o` is high for the first 46 bits and low for the turnaround and data bits. On a write it is high for all 64 bits.
- R9: Read data is sampled on rising MDC edges. The 16 bits, MSB first, appear in bits 15:0 of offset 0xC once busy clears.
- R10: Bit 17 of offset 0xC is set when `mdio_i` is high on the second turnaround bit of a read. It is cleared by a later read whose turnaround is low. A write frame leaves offset 0xC unchanged.
- R11: Busy clears on the rising MDC edge of bit 63. `mdio_oe_o` goes low by the next falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Byte offset of the register access |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for the management data line |
| mdio_i | input | 1 | Management data in |

## Verification
The bench sends several frames and compares every bit at each rising MDC edge against an expected frame built from the command fields:
- A write frame with alternating data.
- A read to the highest PHY address with a responding PHY.
- A read to the highest register address with no PHY present, so the turnaround bit is high.
- A read that follows a failed read.

The two address extremes separate the PHY and register fields and show their bit order. The failed read followed by a good read shows that the error flag both sets and clears.

Rejected commands are sent both while a frame is in progress and while the controller is idle. These cover a missing valid bit, no opcode and both opcodes. Each such case is followed by a readback of the command register and a watch of the line, which distinguishes an ignored command from one that is silently queued.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DATA_W    = 16;
  localparam int ADR_W     = 5;
  localparam int TA_IDX    = 46;            // first turnaround bit
  localparam int DATA_IDX  = TA_IDX + 2;    // first data bit

  localparam int OFF_STAT  = 'h0;
  localparam int OFF_CMD   = 'h8;
  localparam int OFF_DATA  = 'hC;

  typedef struct packed {
    logic              vld;
    logic              rsv30;
    logic [ADR_W-1:0]  phy;
    logic [ADR_W-1:0]  regad;
    logic [DATA_W-1:0] wdata;
    logic              rsv3;
    logic              op_rd;
    logic              op_wr;
    logic              rsv0;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} eng_state_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = (cnt_q == CW'(DIV_HALF - 1));
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_cmd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_err_i,
  output logic              start_o,
  output cmd_t              cmd_o,
  output logic [31:0]       cmd_word_o
);
  cmd_t wcmd;
  logic [31:0] cmd_q;

  assign wcmd    = cmd_t'(reg_wdata_i);
  assign start_o = reg_wr_i && (reg_addr_i == AW'(OFF_CMD)) && !busy_i
                   && wcmd.vld && (wcmd.op_rd ^ wcmd.op_wr);
  assign cmd_o   = wcmd;
  assign cmd_word_o = cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else if (start_o) cmd_q <= {1'b0, reg_wdata_i[30:0]};
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(OFF_STAT))
      reg_rdata_o[3] = busy_i;
    else if (reg_addr_i == AW'(OFF_CMD))
      reg_rdata_o = cmd_q;
    else if (reg_addr_i == AW'(OFF_DATA))
      reg_rdata_o = {14'd0, rd_err_i, 1'b0, rd_data_i};
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_err_o
);
  eng_state_e           state_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [FRAME_LEN-1:0] frame_w;
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W:0]       idx_nxt;
  logic                 is_rd_q, ta_err_q, mdio_q, oe_q;
  logic [DATA_W-1:0]    rd_sh_q, rd_data_q;
  logic                 rd_err_q;

  always_comb begin
    frame_w = {32'hFFFF_FFFF, 2'b01,
               cmd_i.op_rd ? 2'b10 : 2'b01,
               cmd_i.phy, cmd_i.regad,
               cmd_i.op_rd ? 2'b11 : 2'b10,
               cmd_i.op_rd ? {DATA_W{1'b1}} : cmd_i.wdata};
  end

  assign idx_nxt   = {1'b0, idx_q} + 1'b1;
  assign busy_o    = (state_q != ST_IDLE);
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
  assign rd_data_o = rd_data_q;
  assign rd_err_o  = rd_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sh_q      <= '0;
      idx_q     <= '0;
      is_rd_q   <= 1'b0;
      ta_err_q  <= 1'b0;
      mdio_q    <= 1'b1;
      oe_q      <= 1'b0;
      rd_sh_q   <= '0;
      rd_data_q <= '0;
      rd_err_q  <= 1'b0;
    end else if (start_i) begin
      state_q  <= ST_WAIT;
      sh_q     <= frame_w;
      is_rd_q  <= cmd_i.op_rd;
      ta_err_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fall_i) oe_q <= 1'b0;
        ST_WAIT: if (fall_i) begin
          mdio_q  <= sh_q[FRAME_LEN-1];
          sh_q    <= {sh_q[FRAME_LEN-2:0], 1'b1};
          oe_q    <= 1'b1;
          idx_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (fall_i) begin
            mdio_q <= sh_q[FRAME_LEN-1];
            sh_q   <= {sh_q[FRAME_LEN-2:0], 1'b1};
            idx_q  <= idx_nxt[IDX_W-1:0];
            oe_q   <= !is_rd_q || (idx_nxt < (IDX_W+1)'(TA_IDX));
          end
          if (rise_i) begin
            if (is_rd_q && idx_q == IDX_W'(TA_IDX + 1)) ta_err_q <= mdio_i;
            if (is_rd_q && idx_q >= IDX_W'(DATA_IDX))
              rd_sh_q <= {rd_sh_q[DATA_W-2:0], mdio_i};
            if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
              state_q <= ST_IDLE;
              if (is_rd_q) begin
                rd_data_q <= {rd_sh_q[DATA_W-2:0], mdio_i};
                rd_err_q  <= ta_err_q;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int AW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  logic              rise_w, fall_w, busy_w, start_w, rd_err_w;
  logic [DATA_W-1:0] rd_data_w;
  logic [31:0]       cmd_word_w;
  cmd_t              cmd_w;

  mdio_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mdc_o(mdc_o), .rise_o(rise_w), .fall_o(fall_w)
  );

  mdio_regs #(.AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .busy_i(busy_w), .rd_data_i(rd_data_w), .rd_err_i(rd_err_w),
    .start_o(start_w), .cmd_o(cmd_w), .cmd_word_o(cmd_word_w)
  );

  mdio_frame_eng u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rise_i(rise_w), .fall_i(fall_w),
    .start_i(start_w), .cmd_i(cmd_w), .mdio_i(mdio_i),
    .busy_o(busy_w), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
    .rd_data_o(rd_data_w), .rd_err_o(rd_err_w)
  );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk #(
  parameter int DIV_HALF = 4,
  parameter int AW       = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic          mdc_o,
  input logic          mdio_o,
  input logic          mdio_oe_o,
  input logic          busy_i,
  input logic [31:0]   cmd_word_i
);
  logic        mdc_prev_q;
  logic [15:0] hc_q;
  logic        cmd_wr, legal;

  assign cmd_wr = reg_wr_i && (reg_addr_i == AW'(8));
  assign legal  = reg_wdata_i[31] && (reg_wdata_i[2] ^ reg_wdata_i[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_prev_q <= 1'b0;
      hc_q       <= '0;
    end else begin
      mdc_prev_q <= mdc_o;
      if (mdc_o != mdc_prev_q) hc_q <= 16'd1;
      else if (hc_q != 16'hFFFF) hc_q <= hc_q + 16'd1;
    end
  end

  p_mdc_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o != mdc_prev_q) |-> (hc_q == 16'(DIV_HALF)));

  p_line_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mdio_o) || !$stable(mdio_oe_o)) |-> $fell(mdc_o));

  p_busy_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && legal) |=> busy_i);

  p_busy_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_i) |=> $stable(cmd_word_i));

  p_bad_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i && !legal) |=> (!busy_i && $stable(cmd_word_i)));

  p_valid_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_word_i[31]);
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(.DIV_HALF(DIV_HALF), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
  .busy_i(busy_w), .cmd_word_i(cmd_word_w)
);

// File: tb/mdio_cmd_ctrl_tb_top.sv
module mdio_cmd_ctrl_tb_top;
  localparam int DIV_HALF = 3;
  localparam int AW       = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mdc, mdio_out, mdio_oe;
  logic          mdio_in = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit model_busy = 1'b0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  mdio_cmd_ctrl #(.DIV_HALF(DIV_HALF), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit vld, input bit [4:0] phy,
      input bit [4:0] ra, input bit [15:0] d, input bit rd, input bit wr);
    return {vld, 1'b0, phy, ra, d, 1'b0, rd, wr, 1'b0};
  endfunction

  // per-clock busy compare against model (R2, R11)
  always @(negedge clk) begin
    if (mon_on && rst_n && !reg_wr && reg_addr == '0)
      chk("R2/R11 busy", {31'd0, reg_rdata[3]}, {31'd0, model_busy});
  end

  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] w);
    bit acc;
    acc = (a == AW'(8)) && !model_busy && w[31] && (w[2] ^ w[1]);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = w; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = '0;
    if (acc) model_busy = 1'b1;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] r);
    @(negedge clk); #1;
    reg_addr = a; #1;
    r = reg_rdata;
    reg_addr = '0;
  endtask

  // behavioural frame reference: checks every bit at rising MDC
  task automatic frame(input bit rd, input bit [4:0] phy, input bit [4:0] ra,
      input bit [15:0] d, input bit ta_low);
    bit q[$];
    for (int i = 0; i < 32; i++) q.push_back(1'b1);
    q.push_back(1'b0); q.push_back(1'b1);
    q.push_back(rd); q.push_back(!rd);
    for (int i = 4; i >= 0; i--) q.push_back(phy[i]);
    for (int i = 4; i >= 0; i--) q.push_back(ra[i]);
    q.push_back(1'b1); q.push_back(1'b0);
    for (int i = 15; i >= 0; i--) q.push_back(d[i]);
    while (mdio_oe !== 1'b1) @(negedge clk);
    for (int k = 0; k < 64; k++) begin
      bit eoe;
      @(posedge mdc); #1;
      eoe = !rd || (k < 46);
      chk(rd ? "R8 read oe" : "R8 write oe", {31'd0, mdio_oe}, {31'd0, eoe});
      if (eoe) chk("R7 frame bit", {25'd0, k[5:0], mdio_out}, {25'd0, k[5:0], q[k]});
      if (rd && k + 1 == 47) mdio_in = !ta_low;
      else if (rd && k + 1 >= 48 && k + 1 <= 63) mdio_in = d[63 - (k + 1)];
      else mdio_in = 1'b1;
    end
    model_busy = 1'b0;
    mdio_in = 1'b1;
    @(negedge mdc); #1;
    chk("R11 oe released", {31'd0, mdio_oe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, cw;
    int t0, t1, hi;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 reset state
    reg_read(4'h0, r); chk("R1 status", r, 32'd0);
    reg_read(4'h8, r); chk("R1 cmd", r, 32'd0);
    reg_read(4'hC, r); chk("R1 data", r, 32'd0);
    reg_read(4'h4, r); chk("R1 unmapped", r, 32'd0);
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);

    // R6 MDC period
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    chk("R6 mdc period", t1 - t0, 2 * DIV_HALF * 4);

    // write frame
    cw = mk(1, 5'h05, 5'h12, 16'hA5C3, 0, 1);
    fork
      frame(0, 5'h05, 5'h12, 16'hA5C3, 1);
      begin
        reg_write(4'h8, cw);
        reg_read(4'h0, r); chk("R2 busy after accept", r, 32'h8);
      end
    join
    reg_read(4'h8, r); chk("R5 cmd readback", r, cw & 32'h7FFF_FFFF);
    reg_read(4'hC, r); chk("R10 write leaves data", r, 32'd0);

    // read, PHY responds, highest PHY address
    fork
      frame(1, 5'h1F, 5'h00, 16'h1234, 1);
      reg_write(4'h8, mk(1, 5'h1F, 5'h00, 16'h0, 1, 0));
    join
    reg_read(4'hC, r); chk("R9 read data", r, 32'h0000_1234);

    // read, no PHY (turnaround high), highest register address
    fork
      frame(1, 5'h00, 5'h1F, 16'hFFFF, 0);
      reg_write(4'h8, mk(1, 5'h00, 5'h1F, 16'h0, 1, 0));
    join
    reg_read(4'hC, r); chk("R10 error set", r, 32'h0002_FFFF);

    // good read clears error
    fork
      frame(1, 5'h0A, 5'h15, 16'h8001, 1);
      reg_write(4'h8, mk(1, 5'h0A, 5'h15, 16'h0, 1, 0));
    join
    reg_read(4'hC, r); chk("R10 error cleared", r, 32'h0000_8001);

    // command while busy is ignored
    cw = mk(1, 5'h03, 5'h04, 16'h0F0F, 0, 1);
    fork
      frame(0, 5'h03, 5'h04, 16'h0F0F, 1);
      begin
        reg_write(4'h8, cw);
        repeat (40) @(negedge clk);
        reg_write(4'h8, mk(1, 5'h11, 5'h07, 16'h0, 1, 0));
        reg_read(4'h8, r); chk("R3 cmd unchanged while busy", r, cw & 32'h7FFF_FFFF);
      end
    join
    hi = 0;
    repeat (400) begin @(negedge clk); if (mdio_oe) hi++; end
    chk("R3 no second frame", hi, 0);

    // invalid commands ignored
    reg_write(4'h8, mk(0, 5'h01, 5'h02, 16'h1111, 1, 0));
    reg_read(4'h0, r); chk("R4 valid clear no busy", r, 32'd0);
    reg_read(4'h8, r); chk("R4 valid clear cmd kept", r, cw & 32'h7FFF_FFFF);
    reg_write(4'h8, mk(1, 5'h01, 5'h02, 16'h2222, 1, 1));
    reg_read(4'h0, r); chk("R4 both ops no busy", r, 32'd0);
    reg_write(4'h8, mk(1, 5'h01, 5'h02, 16'h3333, 0, 0));
    reg_read(4'h0, r); chk("R4 no op no busy", r, 32'd0);
    reg_read(4'h8, r); chk("R4 cmd kept", r, cw & 32'h7FFF_FFFF);
    hi = 0;
    repeat (200) begin @(negedge clk); if (mdio_oe) hi++; end
    chk("R4 line idle", hi, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule